// File: doc/BRIEF.md
# Decimal Digit Field Move and Compare Engine

This engine operates on unpacked decimal fields held in a byte-wide memory. Each byte carries a decimal digit in its low four bits and a zone in its high four bits. The engine reads and writes only the digit quartets. Two operations are offered. The move operation copies the digit quartets of a source field into a destination field and keeps each destination zone. The compare operation orders two fields as multi-digit numbers and ignores zones.

Both fields are given by the address of their rightmost byte and a shared 8-bit length. Each field extends that many bytes toward lower addresses, and addresses wrap modulo 2^16. A one-cycle `start` launches an operation. When the operation ends, the engine pulses `done` and presents a 2-bit condition code, which holds until the next operation completes. Memory is reached through a single byte port. A read issued in one cycle returns its data on `mem_rdata` in the next cycle, and a write takes effect at the clock edge.

Top module: `nfe_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cc` is 0, `done` is 0, and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: With `op` = 0 (move), every destination byte at `addr_a - k` for k from 0 to len-1 becomes {its own bits 7:4, bits 3:0 of the source byte at `addr_b - k`}. Bytes outside the destination field are not changed.
- R3: Move handles bytes from rightmost to leftmost. For each byte it reads the source, then reads the destination, then writes the destination at that same address. So the k-th write goes to `addr_a - k`.
- R4: After a move, `cc` is 1 if any copied source digit is nonzero and 0 if all copied digits are zero. `cc` bit 1 is always 0 after a move.
- R5: With `op` = 1 (compare), the field bytes are read from the leftmost byte (rightmost address - len + 1) upward, one operand-1 byte and then one operand-2 byte per position. Reading stops after the first position whose digits differ.
- R6: After a compare, `cc` is 1 when operand 1 (at `addr_a`) is less than operand 2 (at `addr_b`), 2 when they are equal, and 3 when operand 1 is greater. Digits are weighted most significant at the left, zones have no effect, and code 0 never occurs.
- R7: A compare never asserts `mem_wr_en`, so neither field is modified.
- R8: A length of 0 performs no memory access and ends with `cc` = 0 for move and `cc` = 2 for compare.
- R9: Field addresses wrap modulo 2^16, both below address 0 and when the leftmost start address of a compare is computed.
- R10: `done` is high for exactly one cycle per operation, and `cc` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation while idle |
| op | input | 1 | 0 = move digits, 1 = compare digits |
| addr_a | input | 16 | Rightmost byte of operand 1 / destination |
| addr_b | input | 16 | Rightmost byte of operand 2 / source |
| len | input | 8 | Field length in bytes |
| mem_addr | output | 16 | Memory byte address |
| mem_rd_en | output | 1 | Read request; data returns the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| cc | output | 2 | Condition code of the last completed operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The early exit of the compare is the hardest case to observe from the ports. The result code does not show where the scan stopped, so the bench logs every read address and checks the count and order of reads against the first differing position. The bench places the difference at each position of fields up to six bytes long, and also leaves the fields with no difference. It gives the two operands different zone bits so that any zone leak changes the result. For wrap-around, the bench places a field across address 0 for both operations and compares the logged 16-bit addresses with the expected values.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  typedef enum logic {
    OP_MOVE = 1'b0,
    OP_CMP  = 1'b1
  } nfe_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_ACT,
    ST_END
  } nfe_state_e;

  localparam logic [1:0] CC_ALLZERO = 2'd0;
  localparam logic [1:0] CC_LT      = 2'd1;
  localparam logic [1:0] CC_EQ      = 2'd2;
  localparam logic [1:0] CC_GT      = 2'd3;
endpackage

// File: rtl/nfe_addr_gen.sv
module nfe_addr_gen #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dir_up,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [AW-1:0] ptr_a,
  output logic [AW-1:0] ptr_b,
  output logic          last
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [LW-1:0] rem;
  logic          up_q;
  logic [AW-1:0] len_ext;

  always_comb begin
    len_ext = '0;
    len_ext[LW-1:0] = len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_a <= '0;
      ptr_b <= '0;
      rem   <= '0;
      up_q  <= 1'b0;
    end else if (load) begin
      up_q  <= dir_up;
      rem   <= len;
      ptr_a <= dir_up ? (base_a - len_ext + ONE) : base_a;
      ptr_b <= dir_up ? (base_b - len_ext + ONE) : base_b;
    end else if (step) begin
      rem   <= rem - 1'b1;
      ptr_a <= up_q ? (ptr_a + ONE) : (ptr_a - ONE);
      ptr_b <= up_q ? (ptr_b + ONE) : (ptr_b - ONE);
    end
  end

  assign last = (rem == {{(LW-1){1'b0}}, 1'b1});

  // R5: a position is never processed beyond the field length
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    step |-> (rem != '0));
endmodule

// File: rtl/nfe_digit_unit.sv
module nfe_digit_unit #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [NW-1:0] first_dig,
  input  logic [DW-1:0] second_byte,
  output logic [DW-1:0] merged,
  output logic          first_nz,
  output logic          lt,
  output logic          gt
);
  logic [NW-1:0] second_dig;

  assign second_dig = second_byte[NW-1:0];
  assign merged     = {second_byte[DW-1:NW], first_dig};
  assign first_nz   = (first_dig != '0);
  assign lt         = (first_dig < second_dig);
  assign gt         = (first_dig > second_dig);
endmodule

// File: rtl/nfe_ctrl.sv
module nfe_ctrl
  import nfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       op_in,
  input  logic       len_zero,
  input  logic       last,
  input  logic       lt,
  input  logic       gt,
  input  logic       dig_nz,
  output nfe_state_e state,
  output nfe_op_e    op_q,
  output logic       load,
  output logic       step,
  output logic [1:0] cc,
  output logic       done
);
  logic       acc_nz;
  logic [1:0] cmp_res;

  assign load = (state == ST_IDLE) && start && !len_zero;
  assign step = (state == ST_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_q    <= OP_MOVE;
      acc_nz  <= 1'b0;
      cmp_res <= CC_EQ;
      cc      <= CC_ALLZERO;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q    <= nfe_op_e'(op_in);
            acc_nz  <= 1'b0;
            cmp_res <= CC_EQ;
            state   <= len_zero ? ST_END : ST_RD1;
          end
        end
        ST_RD1: state <= ST_RD2;
        ST_RD2: state <= ST_ACT;
        ST_ACT: begin
          if (op_q == OP_MOVE) begin
            acc_nz <= acc_nz | dig_nz;
            state  <= last ? ST_END : ST_RD1;
          end else if (lt || gt) begin
            cmp_res <= lt ? CC_LT : CC_GT;
            state   <= ST_END;
          end else begin
            state <= last ? ST_END : ST_RD1;
          end
        end
        ST_END: begin
          done  <= 1'b1;
          cc    <= (op_q == OP_MOVE) ? {1'b0, acc_nz} : cmp_res;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: the code only moves together with done
  assert_cc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cc));
  // R4: move never raises the upper code bit
  assert_move_cc_R4: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_MOVE) |-> !cc[1]);
  // R6: compare never yields code 0
  assert_cmp_cc_R6: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_CMP) |-> (cc != CC_ALLZERO));
endmodule

// File: rtl/nfe_top.sv
module nfe_top
  import nfe_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NW = 4,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr_en,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    cc,
  output logic          done
);
  nfe_state_e    state;
  nfe_op_e       op_q;
  logic          load, step, last;
  logic          lt, gt, dig_nz;
  logic [AW-1:0] ptr_a, ptr_b;
  logic [NW-1:0] hold;
  logic [DW-1:0] merged;
  logic          is_move;

  assign is_move = (op_q == OP_MOVE);

  nfe_addr_gen #(.AW(AW), .LW(LW)) i_addr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .dir_up (op),
    .base_a (addr_a),
    .base_b (addr_b),
    .len    (len),
    .step   (step),
    .ptr_a  (ptr_a),
    .ptr_b  (ptr_b),
    .last   (last)
  );

  nfe_digit_unit #(.DW(DW), .NW(NW)) i_digit (
    .first_dig   (hold),
    .second_byte (mem_rdata),
    .merged      (merged),
    .first_nz    (dig_nz),
    .lt          (lt),
    .gt          (gt)
  );

  nfe_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_in    (op),
    .len_zero (len == '0),
    .last     (last),
    .lt       (lt),
    .gt       (gt),
    .dig_nz   (dig_nz),
    .state    (state),
    .op_q     (op_q),
    .load     (load),
    .step     (step),
    .cc       (cc),
    .done     (done)
  );

  // first byte of a pair: source digit for move, operand-1 digit for compare
  always_ff @(posedge clk) begin
    if (rst) hold <= '0;
    else if (state == ST_RD2) hold <= mem_rdata[NW-1:0];
  end

  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = ptr_a;
    mem_wdata = merged;
    case (state)
      ST_RD1: begin
        mem_rd_en = 1'b1;
        mem_addr  = is_move ? ptr_b : ptr_a;
      end
      ST_RD2: begin
        mem_rd_en = 1'b1;
        mem_addr  = is_move ? ptr_a : ptr_b;
      end
      ST_ACT: begin
        mem_wr_en = is_move;
        mem_addr  = ptr_a;
      end
      default: ;
    endcase
  end

  // R3: each write lands on the byte read just before it
  assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));
  // R7: compare never writes memory
  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> is_move);
  // R3: read and write never share a cycle
  assert_port_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/test_nfe_top.sv
module test_nfe_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [15:0] addr_a = '0, addr_b = '0;
  logic [7:0]  len = '0;
  logic [15:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_rdata, mem_wdata;
  logic [1:0]  cc;
  logic        done;

  logic        ld_en = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  mem [0:4095];
  logic [15:0] rd_log [0:63];
  logic [15:0] wr_log [0:63];
  int          rd_cnt = 0, wr_cnt = 0;
  int          n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  nfe_top i_nfe_top (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr_a(addr_a),
    .addr_b(addr_b), .len(len), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .cc(cc), .done(done)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr[11:0]] <= ld_data;
    else if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_rd_en) begin rd_log[rd_cnt % 64] <= mem_addr; rd_cnt <= rd_cnt + 1; end
    if (mem_wr_en) begin wr_log[wr_cnt % 64] <= mem_addr; wr_cnt <= wr_cnt + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  logic [1:0] got_cc;
  int         rd0, wr0;

  task automatic run_op(input logic o, input logic [15:0] a, input logic [15:0] b,
                        input logic [7:0] n);
    int cyc;
    rd0 = rd_cnt; wr0 = wr_cnt;
    op = o; addr_a = a; addr_b = b; len = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check(done, "R10 done seen", int'(done), 1);
    got_cc = cc;
    @(negedge clk);
    check(!done && cc == got_cc, "R10 single pulse, cc held", {done, cc}, {1'b0, got_cc});
  endtask

  function automatic logic [3:0] pat(input int s, input int k);
    return 4'((s * 7 + k * 11 + (s >> 1) * k) % 16);
  endfunction

  logic [7:0] dv [0:7];
  logic [7:0] sv [0:7];

  // move: dst rightmost d, src rightmost s, n bytes; zero_dig forces digits 0
  task automatic do_move(input logic [15:0] d, input logic [15:0] s, input int n,
                         input int seed, input bit zero_dig);
    bit ok; bit nz;
    nz = 1'b0;
    for (int k = 0; k < n; k++) begin
      dv[k] = {pat(seed + 3, k), pat(seed + 5, k)};
      sv[k] = {pat(seed + 9, k), zero_dig ? 4'h0 : pat(seed, k)};
      if (sv[k][3:0] != 0) nz = 1'b1;
      poke(d - 16'(k), dv[k]);
      poke(s - 16'(k), sv[k]);
    end
    poke(d + 16'd1, 8'hA5);
    poke(d - 16'(n), 8'h5A);
    run_op(1'b0, d, s, 8'(n));
    ok = 1'b1;
    for (int k = 0; k < n; k++)
      if (mem[12'(d - 16'(k))] != {dv[k][7:4], sv[k][3:0]}) ok = 1'b0;
    check(ok, "R2 dst digits replaced, zones kept", n, seed);
    check(mem[12'(d + 16'd1)] == 8'hA5 && mem[12'(d - 16'(n))] == 8'h5A,
          "R2 neighbours untouched", mem[12'(d + 16'd1)], 8'hA5);
    check(got_cc == {1'b0, nz}, "R4 move code", got_cc, {1'b0, nz});
    ok = (rd_cnt - rd0 == 2 * n) && (wr_cnt - wr0 == n);
    for (int k = 0; k < n; k++) begin
      if (rd_log[(rd0 + 2 * k) % 64] != s - 16'(k)) ok = 1'b0;
      if (rd_log[(rd0 + 2 * k + 1) % 64] != d - 16'(k)) ok = 1'b0;
      if (wr_log[(wr0 + k) % 64] != d - 16'(k)) ok = 1'b0;
    end
    check(ok, "R3/R9 move access order", rd_cnt - rd0, 2 * n);
  endtask

  // compare: operand1 rightmost a, operand2 rightmost b; digit differs at p (p==n: none)
  task automatic do_cmp(input logic [15:0] a, input logic [15:0] b, input int n,
                        input int seed, input int p, input logic [3:0] x);
    bit ok; int m; logic [31:0] va, vb; logic [1:0] exp_cc;
    logic [3:0] da, db;
    va = 0; vb = 0; m = n;
    for (int k = 0; k < n; k++) begin
      da = pat(seed, k);
      db = (k == p) ? (da ^ x) : da;
      if (da != db && m == n) m = k + 1;
      va = (va << 4) | 32'(da);
      vb = (vb << 4) | 32'(db);
      poke(a - 16'(n - 1 - k), {pat(seed + 1, k), da});
      poke(b - 16'(n - 1 - k), {pat(seed + 6, k) ^ 4'h9, db});
    end
    exp_cc = (va < vb) ? 2'd1 : (va == vb) ? 2'd2 : 2'd3;
    run_op(1'b1, a, b, 8'(n));
    check(got_cc == exp_cc, "R6 compare code, zones ignored", got_cc, exp_cc);
    ok = (rd_cnt - rd0 == 2 * m);
    for (int k = 0; k < m; k++) begin
      if (rd_log[(rd0 + 2 * k) % 64] != a - 16'(n) + 16'(k) + 16'd1) ok = 1'b0;
      if (rd_log[(rd0 + 2 * k + 1) % 64] != b - 16'(n) + 16'(k) + 16'd1) ok = 1'b0;
    end
    check(ok, "R5/R9 compare read order and early stop", rd_cnt - rd0, 2 * m);
    check(wr_cnt == wr0, "R7 compare writes nothing", wr_cnt - wr0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) begin
      @(negedge clk);
      check(cc == 2'd0 && !done && !mem_rd_en && !mem_wr_en, "R1 reset state",
            {cc, done, mem_rd_en, mem_wr_en}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(cc == 2'd0 && !done && !mem_rd_en && !mem_wr_en, "R1 after reset",
          {cc, done, mem_rd_en, mem_wr_en}, 0);

    // R8: zero length
    run_op(1'b0, 16'h0120, 16'h0320, 8'd0);
    check(got_cc == 2'd0 && rd_cnt == rd0 && wr_cnt == wr0, "R8 move len 0",
          got_cc, 0);
    run_op(1'b1, 16'h0120, 16'h0320, 8'd0);
    check(got_cc == 2'd2 && rd_cnt == rd0 && wr_cnt == wr0, "R8 compare len 0",
          got_cc, 2);

    // R6: every single-digit pair
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        poke(16'h0140, {4'(i * 3), 4'(i)});
        poke(16'h0340, {4'(j * 5 + 1), 4'(j)});
        run_op(1'b1, 16'h0140, 16'h0340, 8'd1);
        check(got_cc == ((i < j) ? 2'd1 : (i == j) ? 2'd2 : 2'd3),
              "R6 single digit order", got_cc, (i < j) ? 1 : (i == j) ? 2 : 3);
      end

    // R5/R6: difference at each position
    for (int n = 1; n <= 6; n++)
      for (int p = 0; p <= n; p++)
        for (int xi = 0; xi < 3; xi++)
          do_cmp(16'h0160, 16'h0360, n, n * 5 + p, p, (xi == 0) ? 4'h1 : (xi == 1) ? 4'h8 : 4'hF);

    // R2/R3/R4: move sweep
    for (int n = 1; n <= 8; n++) begin
      for (int s = 0; s < 5; s++) do_move(16'h0190, 16'h0390, n, n * 3 + s, 1'b0);
      do_move(16'h0190, 16'h0390, n, n, 1'b1);
    end

    // R9: fields across address 0
    do_move(16'h0001, 16'h0203, 4, 2, 1'b0);
    do_cmp(16'h0002, 16'h0383, 5, 4, 3, 4'h6);
    do_cmp(16'h0002, 16'h0383, 5, 7, 5, 4'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule